// File: doc/BRIEF.md
# Command-Driven I2C Master

This block is an I2C bus master that moves one byte per software command. Software loads a target address with a direction bit and, for a write, a data byte, then writes a command word. The command word can ask for a START condition before the byte and a STOP condition after it. It also says whether a received byte is acknowledged. Between commands the master can keep ownership of the bus, so software can chain further bytes or a repeated START without releasing SCL. The block signals completion or an abort through an interrupt bit that has a mask and a write-one-to-clear register.

On the bus side the block drives open-drain enables for SCL and SDA and samples SDA. Each bit is split into four equal quarters: two with SCL low and two with SCL high. SDA is set up in the second low quarter and sampled at the end of the second high quarter. The engine has six states. IDLE means the bus is free. START raises SCL if needed and pulls SDA low while SCL is high. ADDR shifts out the address and direction and then samples the acknowledge. DATA shifts one byte in either direction plus the acknowledge bit. STOP drives SDA low under a low SCL and releases it while SCL is high. HOLD means the byte is finished and the bus is kept with SCL low.

The transitions are as follows. IDLE goes to START on a START command, and HOLD goes to START on a repeated START. HOLD goes to DATA on a plain RUN command. START goes to ADDR. ADDR goes to DATA on an acknowledge and to STOP on a NACK. DATA goes to STOP when a STOP was requested or a write byte was NACKed, and otherwise to HOLD. STOP goes to IDLE.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, scl_oe and sda_oe are 0, the status register (offset 2) reads 0 and irq is 0.
- R2: A command with RUN (bit 0) and START (bit 1) on a free bus gives a START condition. The 8-bit address register (offset 0) is then sent MSB first: address in bits 7:1, then bit 0 as direction (1 = read).
- R3: SCL is low for (P+1)*CLK_SCALE clocks and high for (P+1)*CLK_SCALE clocks within a byte, where P is the period register (offset 3).
- R4: SDA changes only while SCL is low, except for the START, repeated START and STOP conditions.
- R5: On a write, after the address is acknowledged, the data register (offset 1) is sent. With STOP (bit 2) set, the transfer ends with a STOP condition and the bus is released. The ACK bit (bit 3) has no effect on a write.
- R6: On a read, the received byte is placed in the data register. The master drives an acknowledge when ACK=1 and a NACK when ACK=0.
- R7: With STOP=0 the bus stays owned: status bit 4 stays set, no STOP condition is generated, and a later START command produces a repeated START.
- R8: A NACK of the address produces a STOP and no data byte. Status then reads error (bit 1) and address NACK (bit 2).
- R9: A NACK of a written data byte produces a STOP and sets error (bit 1) and data NACK (bit 3).
- R10: Completion or abort sets the raw interrupt (offset 4, bit 0). The masked register (offset 6) and irq equal raw AND mask (offset 5). Writing 1 to bit 0 of offset 7 clears the raw bit.
- R11: A command written while busy (status bit 0) is ignored.
- R12: A RUN command without START while the bus is not owned is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_sel | input | 3 | Register offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_sel |
| irq | output | 1 | Masked interrupt |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sampled SDA line |

## Verification
The bench builds the block with CLK_SCALE=4 and writes 1 to the period register. A half SCL period is then 8 clocks and a byte takes about 150 clocks. This short bit time lets the bench run many scenarios: writes, reads with both acknowledge settings, repeated STARTs and both kinds of NACK, each against a behavioural target on the open-drain bus. The same short period lets the bench count exact SCL high and low durations. Because START and STOP conditions are counted on the wire, any stray SDA edge while SCL is high shows up as a wrong count.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_START, S_ADDR, S_DATA, S_STOP, S_HOLD
    } i2cm_state_e;

    localparam logic [2:0] REG_TADDR  = 3'd0;
    localparam logic [2:0] REG_DATA   = 3'd1;
    localparam logic [2:0] REG_CMD    = 3'd2;
    localparam logic [2:0] REG_PERIOD = 3'd3;
    localparam logic [2:0] REG_RAW    = 3'd4;
    localparam logic [2:0] REG_MASK   = 3'd5;
    localparam logic [2:0] REG_MIS    = 3'd6;
    localparam logic [2:0] REG_CLR    = 3'd7;

    localparam int CMD_RUN   = 0;
    localparam int CMD_START = 1;
    localparam int CMD_STOP  = 2;
    localparam int CMD_ACK   = 3;
endpackage

// File: rtl/i2cm_timer.sv
module i2cm_timer #(
    parameter int CLK_SCALE = 10,
    parameter int PER_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [PER_W-1:0] period,
    output logic             tick
);
    localparam int QUARTER = CLK_SCALE / 2;
    localparam int CNT_W   = PER_W + $clog2(CLK_SCALE) + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload;

    assign reload = CNT_W'((32'(period) + 32'd1) * 32'(QUARTER) - 32'd1);
    assign tick   = run && !restart && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= reload;
        end else if (run) begin
            if (cnt_q == '0) cnt_q <= reload;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmd_go,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              cmd_ack,
    input  logic [BYTE_W-1:0] tgt_addr,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              sda_in,
    output logic              busy,
    output logic              owned,
    output logic              err_adr,
    output logic              err_dat,
    output logic              done,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              scl_oe,
    output logic              sda_oe
);
    localparam int BIT_W = $clog2(BYTE_W + 1);
    localparam logic [BIT_W-1:0] ACK_BIT = BIT_W'(BYTE_W);

    i2cm_state_e       state;
    logic [1:0]        phase;
    logic [BIT_W-1:0]  bitn;
    logic [BYTE_W-1:0] shift;
    logic              dir_q, ack_q, stop_q, sda_drv;

    assign busy    = (state != S_IDLE) && (state != S_HOLD);
    assign rx_byte = shift;
    assign sda_oe  = sda_drv;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            phase    <= 2'd0;
            bitn     <= '0;
            shift    <= '0;
            dir_q    <= 1'b0;
            ack_q    <= 1'b0;
            stop_q   <= 1'b0;
            sda_drv  <= 1'b0;
            owned    <= 1'b0;
            err_adr  <= 1'b0;
            err_dat  <= 1'b0;
            done     <= 1'b0;
            rx_valid <= 1'b0;
        end else begin
            done     <= 1'b0;
            rx_valid <= 1'b0;
            if (cmd_go) begin
                stop_q  <= cmd_stop;
                ack_q   <= cmd_ack;
                err_adr <= 1'b0;
                err_dat <= 1'b0;
                phase   <= 2'd0;
                bitn    <= '0;
                if (cmd_start) begin
                    dir_q   <= tgt_addr[0];
                    shift   <= tgt_addr;
                    sda_drv <= 1'b0;
                    state   <= S_START;
                end else begin
                    shift   <= tx_byte;
                    state   <= S_DATA;
                end
            end else if (tick) begin
                phase <= phase + 2'd1;
                unique case (state)
                    S_START: begin
                        if (phase == 2'd1) begin
                            sda_drv <= 1'b1;
                            owned   <= 1'b1;
                        end
                        if (phase == 2'd3) begin
                            state <= S_ADDR;
                            bitn  <= '0;
                        end
                    end
                    S_ADDR, S_DATA: begin
                        if (phase == 2'd0) begin
                            if (bitn == ACK_BIT)
                                sda_drv <= (state == S_DATA) && dir_q && ack_q;
                            else
                                sda_drv <= !(state == S_DATA && dir_q) && !shift[BYTE_W-1];
                        end
                        if (phase == 2'd3) begin
                            if (bitn != ACK_BIT) begin
                                shift <= {shift[BYTE_W-2:0], sda_in};
                                bitn  <= bitn + 1'b1;
                            end else begin
                                bitn <= '0;
                                if (state == S_ADDR) begin
                                    if (sda_in) begin
                                        err_adr <= 1'b1;
                                        state   <= S_STOP;
                                    end else begin
                                        state <= S_DATA;
                                        if (!dir_q) shift <= tx_byte;
                                    end
                                end else begin
                                    if (dir_q) rx_valid <= 1'b1;
                                    if (!dir_q && sda_in) begin
                                        err_dat <= 1'b1;
                                        state   <= S_STOP;
                                    end else if (stop_q) begin
                                        state <= S_STOP;
                                    end else begin
                                        state <= S_HOLD;
                                        done  <= 1'b1;
                                    end
                                end
                            end
                        end
                    end
                    S_STOP: begin
                        if (phase == 2'd0) sda_drv <= 1'b1;
                        if (phase == 2'd2) begin
                            sda_drv <= 1'b0;
                            owned   <= 1'b0;
                        end
                        if (phase == 2'd3) begin
                            state <= S_IDLE;
                            done  <= 1'b1;
                        end
                    end
                    S_IDLE, S_HOLD: ;
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    // bus outputs
    always_comb begin
        unique case (state)
            S_IDLE:          scl_oe = 1'b0;
            S_HOLD:          scl_oe = 1'b1;
            S_START:         scl_oe = (phase == 2'd0) ? owned : (phase == 2'd3);
            S_ADDR, S_DATA:  scl_oe = (phase < 2'd2);
            S_STOP:          scl_oe = (phase < 2'd2);
            default:         scl_oe = 1'b0;
        endcase
    end

    assert_sda_low_scl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_ADDR || state == S_DATA) && !$stable(sda_drv)) |-> (scl_oe && $past(scl_oe)));

    assert_cmd_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |-> !busy);

    assert_adr_nack_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_adr) |-> (state == S_STOP));

    assert_release_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(owned) |-> (!sda_oe && state == S_STOP));
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
    import i2cm_pkg::*;
#(
    parameter int CLK_SCALE = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] reg_sel,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic       sda_in
);
    localparam int BYTE_W = 8;

    logic [BYTE_W-1:0] taddr_q, data_q, period_q, rx_byte;
    logic raw_q, mask_q;
    logic busy, owned, err_adr, err_dat, done, rx_valid, tick;
    logic cmd_wr, cmd_go;

    assign cmd_wr = reg_we && (reg_sel == REG_CMD);
    assign cmd_go = cmd_wr && reg_wdata[CMD_RUN] && !busy
                    && (reg_wdata[CMD_START] || owned);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taddr_q  <= '0;
            data_q   <= '0;
            period_q <= '0;
            raw_q    <= 1'b0;
            mask_q   <= 1'b0;
        end else begin
            if (reg_we && reg_sel == REG_TADDR)  taddr_q  <= reg_wdata;
            if (reg_we && reg_sel == REG_PERIOD) period_q <= reg_wdata;
            if (reg_we && reg_sel == REG_MASK)   mask_q   <= reg_wdata[0];
            if (rx_valid)                            data_q <= rx_byte;
            else if (reg_we && reg_sel == REG_DATA)  data_q <= reg_wdata;
            if (done)                                        raw_q <= 1'b1;
            else if (reg_we && reg_sel == REG_CLR && reg_wdata[0]) raw_q <= 1'b0;
        end
    end

    assign irq = raw_q && mask_q;

    always_comb begin
        unique case (reg_sel)
            REG_TADDR:  reg_rdata = taddr_q;
            REG_DATA:   reg_rdata = data_q;
            REG_CMD:    reg_rdata = {3'b000, owned, err_dat, err_adr, err_adr | err_dat, busy};
            REG_PERIOD: reg_rdata = period_q;
            REG_RAW:    reg_rdata = {7'd0, raw_q};
            REG_MASK:   reg_rdata = {7'd0, mask_q};
            REG_MIS:    reg_rdata = {7'd0, raw_q & mask_q};
            default:    reg_rdata = 8'd0;
        endcase
    end

    i2cm_timer #(.CLK_SCALE(CLK_SCALE), .PER_W(BYTE_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(cmd_go), .run(busy),
        .period(period_q), .tick(tick)
    );

    i2cm_engine #(.BYTE_W(BYTE_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_go(cmd_go),
        .cmd_start(reg_wdata[CMD_START]), .cmd_stop(reg_wdata[CMD_STOP]),
        .cmd_ack(reg_wdata[CMD_ACK]), .tgt_addr(taddr_q), .tx_byte(data_q),
        .sda_in(sda_in), .busy(busy), .owned(owned), .err_adr(err_adr),
        .err_dat(err_dat), .done(done), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    assert_irq_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> raw_q);

    assert_no_start_free_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !reg_wdata[CMD_START] && !owned && !busy) |=> !busy);
endmodule

// File: tb/test_i2c_cmd_master.sv
`timescale 1ns/1ps
module test_i2c_cmd_master;
    localparam int CLK_SCALE = 4;
    localparam int PERIOD    = 1;
    localparam int HALF      = (PERIOD + 1) * CLK_SCALE;
    localparam logic [6:0] TADDR = 7'h2A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] reg_sel = 3'd0;
    logic reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic irq, scl_oe, sda_oe;
    logic tgt_pull = 1'b0;
    wire  scl_w = !scl_oe;
    wire  sda_w = !(sda_oe || tgt_pull);

    int checks = 0, fails = 0, cyc = 0;

    always #4 clk = !clk;
    always @(posedge clk) cyc <= cyc + 1;

    i2c_cmd_master #(.CLK_SCALE(CLK_SCALE)) i_i2c_cmd_master (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_w)
    );

    // behavioural target
    logic p_scl = 1'b1, p_sda = 1'b1, m_ack = 1'b0, matched = 1'b0;
    logic tgt_nack_data = 1'b0;
    logic [7:0] tgt_tx = 8'h00, shreg = 8'h00, last_addr = 8'h00, last_wr = 8'h00;
    int mode = 0, cnt = 0, start_cnt = 0, stop_cnt = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_scl && scl_w && p_sda && !sda_w) begin
                mode = 1; cnt = 0; tgt_pull = 1'b0; start_cnt++;
            end else if (p_scl && scl_w && !p_sda && sda_w) begin
                mode = 0; tgt_pull = 1'b0; stop_cnt++;
            end else if (!p_scl && scl_w) begin
                if (mode == 1 || mode == 2) begin
                    if (cnt < 8) begin shreg = {shreg[6:0], sda_w}; cnt++; end
                end else if (mode == 3) begin
                    if (cnt == 8) m_ack = !sda_w;
                    cnt++;
                end
            end else if (p_scl && !scl_w) begin
                if (mode == 1) begin
                    if (cnt == 8) begin
                        last_addr = shreg; matched = (shreg[7:1] == TADDR);
                        tgt_pull = matched; cnt = 9;
                    end else if (cnt == 9) begin
                        tgt_pull = 1'b0; cnt = 0;
                        if (!matched) mode = 0;
                        else if (last_addr[0]) begin mode = 3; tgt_pull = !tgt_tx[7]; end
                        else mode = 2;
                    end
                end else if (mode == 2) begin
                    if (cnt == 8) begin last_wr = shreg; tgt_pull = !tgt_nack_data; cnt = 9; end
                    else if (cnt == 9) begin tgt_pull = 1'b0; cnt = 0; end
                end else if (mode == 3) begin
                    if (cnt < 8) tgt_pull = !tgt_tx[7-cnt];
                    else if (cnt == 8) tgt_pull = 1'b0;
                    else if (m_ack) begin cnt = 0; tgt_pull = !tgt_tx[7]; end
                    else begin mode = 0; tgt_pull = 1'b0; end
                end
            end
            p_scl = scl_w; p_sda = sda_w;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk); reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [7:0] d);
        @(negedge clk); reg_sel = sel; #1; d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 4000; i++) begin
            rd(3'd2, s);
            if (!s[0]) break;
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] s;
        chk("R1 scl_oe", scl_oe, 0);
        chk("R1 sda_oe", sda_oe, 0);
        rd(3'd2, s); chk("R1 status", s, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_write();
        logic [7:0] s;
        int s0 = start_cnt, p0 = stop_cnt, t1, t2, t3;
        wr(3'd0, {TADDR, 1'b0}); wr(3'd1, 8'hA5);
        wr(3'd2, 8'h0F);                         // ACK set, no effect on write (R5)
        @(posedge scl_w); t1 = cyc;
        @(negedge scl_w); t2 = cyc;
        @(posedge scl_w); t3 = cyc;
        chk("R3 scl high", t2 - t1, HALF);
        chk("R3 scl low", t3 - t2, HALF);
        wait_idle();
        chk("R2 address byte", last_addr, 8'h54);
        chk("R5 data byte", last_wr, 8'hA5);
        chk("R4 start count", start_cnt - s0, 1);
        chk("R4 stop count", stop_cnt - p0, 1);
        rd(3'd2, s); chk("R5 status free", s, 0);
        rd(3'd4, s); chk("R10 raw set", s, 1);
        chk("R10 irq masked off", irq, 0);
    endtask

    task automatic t_irq();
        logic [7:0] s;
        wr(3'd5, 8'h01);
        chk("R10 irq on", irq, 1);
        rd(3'd6, s); chk("R10 masked", s, 1);
        wr(3'd7, 8'h01);
        rd(3'd4, s); chk("R10 raw cleared", s, 0);
        chk("R10 irq off", irq, 0);
        wr(3'd5, 8'h00);
    endtask

    task automatic t_read();
        logic [7:0] s;
        int p0 = stop_cnt;
        tgt_tx = 8'h3C;
        wr(3'd0, {TADDR, 1'b1}); wr(3'd2, 8'h0B);
        wait_idle();
        rd(3'd1, s); chk("R6 rx byte", s, 8'h3C);
        chk("R6 master ack", m_ack, 1);
        rd(3'd2, s); chk("R7 owned", s, 8'h10);
        chk("R7 no stop", stop_cnt - p0, 0);
        tgt_tx = 8'h3D;
        wr(3'd2, 8'h05);
        wait_idle();
        rd(3'd1, s); chk("R6 second byte", s, 8'h3D);
        chk("R6 master nack", m_ack, 0);
        chk("R6 stop", stop_cnt - p0, 1);
        rd(3'd2, s); chk("R6 status free", s, 0);
    endtask

    task automatic t_restart();
        logic [7:0] s;
        int s0 = start_cnt, p0 = stop_cnt;
        wr(3'd0, {TADDR, 1'b0}); wr(3'd1, 8'h11); wr(3'd2, 8'h03);
        wait_idle();
        tgt_tx = 8'h96;
        wr(3'd0, {TADDR, 1'b1}); wr(3'd2, 8'h07);
        wait_idle();
        chk("R7 start count", start_cnt - s0, 2);
        chk("R7 stop count", stop_cnt - p0, 1);
        chk("R7 first write", last_wr, 8'h11);
        rd(3'd1, s); chk("R7 read after restart", s, 8'h96);
    endtask

    task automatic t_adr_nack();
        logic [7:0] s;
        int p0 = stop_cnt;
        wr(3'd7, 8'h01);
        wr(3'd0, 8'h40); wr(3'd1, 8'h77); wr(3'd2, 8'h07);
        wait_idle();
        rd(3'd2, s); chk("R8 status", s, 8'h06);
        chk("R8 no data byte", last_wr, 8'h11);
        chk("R8 stop", stop_cnt - p0, 1);
        rd(3'd4, s); chk("R8 raw irq", s, 1);
    endtask

    task automatic t_dat_nack();
        logic [7:0] s;
        int p0 = stop_cnt;
        tgt_nack_data = 1'b1;
        wr(3'd0, {TADDR, 1'b0}); wr(3'd1, 8'h5A); wr(3'd2, 8'h07);
        wait_idle();
        rd(3'd2, s); chk("R9 status", s, 8'h0A);
        chk("R9 byte seen", last_wr, 8'h5A);
        chk("R9 stop", stop_cnt - p0, 1);
        tgt_nack_data = 1'b0;
    endtask

    task automatic t_busy();
        int s0 = start_cnt, p0 = stop_cnt;
        wr(3'd1, 8'h33); wr(3'd2, 8'h07);
        repeat (3) @(negedge clk);
        wr(3'd2, 8'h07);
        wait_idle();
        repeat (60) @(negedge clk);
        chk("R11 one start", start_cnt - s0, 1);
        chk("R11 one stop", stop_cnt - p0, 1);
        chk("R11 bus idle", scl_oe, 0);
    endtask

    task automatic t_nostart();
        logic [7:0] s;
        int s0 = start_cnt;
        wr(3'd7, 8'h01);
        wr(3'd2, 8'h05);
        rd(3'd2, s); chk("R12 not busy", s, 0);
        repeat (40) @(negedge clk);
        chk("R12 scl idle", scl_oe, 0);
        chk("R12 no start", start_cnt - s0, 0);
        rd(3'd4, s); chk("R12 no irq", s, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        wr(3'd3, 8'(PERIOD));
        t_write();
        t_irq();
        t_read();
        t_restart();
        t_adr_nack();
        t_dat_nack();
        t_busy();
        t_nostart();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule